// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block sits between eight device request lines and one CPU interrupt input. Every request line is sampled into a sticky pending bit. Of the pending lines that are not masked, the one with the highest index is picked. Its vector number, a programmable base plus the line index, is loaded into a held register, and the interrupt output is raised. The output and the vector stay put until the CPU acknowledges. The acknowledge moves the chosen line from pending to in-service.

The in-service bits form a stack of nested priority levels. While any level is in service, only lines with a strictly higher index may raise a new interrupt. An end-of-interrupt pulse pops the highest in-service level, and lower requests that were held back can then compete again. Software sees two read values: a cause value, made of the pending bits that are not masked, and a status value, made of the in-service bits. It programs the mask and the vector base through write strobes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, intOut is 0, vectorOut is 0x00, causeOut is 0x00, statusOut is 0x00, the mask is 0x00 (all lines enabled) and the vector base is 0x20.
- R2: A request line that is high at a clock edge sets its pending bit at that edge. The bit stays set after the line drops, until the request is acknowledged. causeOut shows pending AND NOT mask, bit i for line i.
- R3: intOut rises at the clock edge after an eligible cause bit appears. At that edge vectorOut loads (base + line index) modulo 256.
- R4: When several lines are eligible, the line with the highest index (line 7 highest, line 0 lowest) is chosen.
- R5: A masked line still sets its pending bit, but it shows no cause bit and never raises intOut. Unmasking it later makes it eligible.
- R6: While intOut is high and intAck is low, intOut and vectorOut hold their values, even if a higher-priority request arrives.
- R7: An intAck sampled while intOut is high drops intOut at that edge, clears the chosen line's pending bit and sets its statusOut bit.
- R8: While statusOut is non-zero with its highest set bit at index L, only eligible lines with index greater than L may raise intOut. Lines at L or below stay pending.
- R9: An eoi pulse clears the highest set statusOut bit at that edge. Requests held back by that level may then be granted at the next edge.
- R10: A base write (baseWr with baseData) changes the vector of later grants. A mask write (maskWr with maskData) takes effect at that edge, and a mask bit of 1 disables line i.
- R11: An intAck sampled while intOut is low has no effect on statusOut, causeOut or intOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 8 | Device request lines, level sampled |
| maskWr | input | 1 | Write strobe for the mask register |
| maskData | input | 8 | New mask value, 1 disables a line |
| baseWr | input | 1 | Write strobe for the vector base |
| baseData | input | 8 | New vector base |
| intAck | input | 1 | CPU acknowledge of the raised interrupt |
| eoi | input | 1 | End of interrupt, pops the highest in-service level |
| intOut | output | 1 | Interrupt request to the CPU |
| vectorOut | output | 8 | Vector of the interrupt being raised |
| causeOut | output | 8 | Pending and unmasked lines |
| statusOut | output | 8 | In-service levels |

## Verification
A request line driven high for one cycle shows in causeOut right after the edge that samples it. intOut and vectorOut follow one edge later, so the bench checks that intOut is still low at the first sample point and high at the second. The effects of acknowledge, end-of-interrupt and register writes land at the edge that samples the strobe, so they are checked at the next falling edge. A grant released by an end-of-interrupt or an unmask needs one more edge, and the bench checks both the quiet cycle and the cycle of the grant.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctlState_t;

  typedef struct packed {
    logic loadVec;
    logic take;
    logic popIsr;
  } ctlStrobe_t;

endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] bits,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (bits[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] BASE_RESET = 8'h20,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 maskWr,
  input  logic [NUM_LINES-1:0] maskData,
  input  logic                 baseWr,
  input  logic [VEC_W-1:0]     baseData,
  input  ctlStrobe_t           strobe,
  output logic                 anyElig,
  output logic [VEC_W-1:0]     vectorOut,
  output logic [NUM_LINES-1:0] causeOut,
  output logic [NUM_LINES-1:0] statusOut
);

  logic [NUM_LINES-1:0] pendQ, maskQ, isrQ;
  logic [VEC_W-1:0]     baseQ, vecQ;
  logic [IDX_W-1:0]     selIdxQ;

  logic [NUM_LINES-1:0] cause, elig, takeBit, popBit;
  logic [IDX_W-1:0]     topIdx, winIdx;
  logic                 anyIsr;

  assign cause = pendQ & ~maskQ;

  prio_pick #(.WIDTH(NUM_LINES)) uTopIsr (
    .bits(isrQ),
    .idx (topIdx),
    .any (anyIsr)
  );

  // a line is eligible when unmasked, pending, and above the nesting level
  for (genvar i = 0; i < NUM_LINES; i++) begin : gElig
    assign elig[i] = cause[i] && (!anyIsr || (IDX_W'(i) > topIdx));
  end

  prio_pick #(.WIDTH(NUM_LINES)) uWinner (
    .bits(elig),
    .idx (winIdx),
    .any (anyElig)
  );

  always_comb begin
    takeBit = '0;
    popBit  = '0;
    if (strobe.take) takeBit[selIdxQ] = 1'b1;
    if (strobe.popIsr && anyIsr) popBit[topIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      maskQ   <= '0;
      baseQ   <= BASE_RESET;
      isrQ    <= '0;
      vecQ    <= '0;
      selIdxQ <= '0;
    end else begin
      pendQ <= (pendQ | irqReq) & ~takeBit;
      isrQ  <= (isrQ & ~popBit) | takeBit;
      if (maskWr) maskQ <= maskData;
      if (baseWr) baseQ <= baseData;
      if (strobe.loadVec) begin
        vecQ    <= baseQ + VEC_W'(winIdx);
        selIdxQ <= winIdx;
      end
    end
  end

  assign vectorOut = vecQ;
  assign causeOut  = cause;
  assign statusOut = isrQ;

  AST_NEST_ONLY_HIGHER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadVec && anyIsr |-> winIdx > topIdx); // R8
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadVec |-> !maskQ[winIdx] && pendQ[winIdx]); // R5
  AST_EOI_POPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popIsr && anyIsr && !strobe.take
    |=> $countones(isrQ) == $past($countones(isrQ)) - 1); // R9

endmodule

// File: rtl/prio_irq_control.sv
module prio_irq_control
  import prio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyElig,
  input  logic       intAck,
  input  logic       eoi,
  output ctlStrobe_t strobe,
  output logic       intOut
);

  ctlState_t stateQ, stateD;

  always_comb begin
    stateD         = stateQ;
    strobe.loadVec = 1'b0;
    strobe.take    = 1'b0;
    strobe.popIsr  = eoi;
    case (stateQ)
      ST_IDLE: begin
        if (anyElig) begin
          strobe.loadVec = 1'b1;
          stateD         = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (intAck) begin
          strobe.take = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign intOut = (stateQ == ST_WAIT);

  AST_GRANT_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadVec |=> intOut); // R3

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 maskWr,
  input  logic [NUM_LINES-1:0] maskData,
  input  logic                 baseWr,
  input  logic [VEC_W-1:0]     baseData,
  input  logic                 intAck,
  input  logic                 eoi,
  output logic                 intOut,
  output logic [VEC_W-1:0]     vectorOut,
  output logic [NUM_LINES-1:0] causeOut,
  output logic [NUM_LINES-1:0] statusOut
);

  ctlStrobe_t strobe;
  logic       anyElig;

  prio_irq_datapath #(
    .NUM_LINES(NUM_LINES),
    .VEC_W    (VEC_W)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .maskWr   (maskWr),
    .maskData (maskData),
    .baseWr   (baseWr),
    .baseData (baseData),
    .strobe   (strobe),
    .anyElig  (anyElig),
    .vectorOut(vectorOut),
    .causeOut (causeOut),
    .statusOut(statusOut)
  );

  prio_irq_control uControl (
    .clk    (clk),
    .rstN   (rstN),
    .anyElig(anyElig),
    .intAck (intAck),
    .eoi    (eoi),
    .strobe (strobe),
    .intOut (intOut)
  );

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    intOut && !intAck |=> intOut && $stable(vectorOut)); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    intOut && intAck |=> !intOut && (statusOut != '0)); // R7
  AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rstN)
    !intOut && intAck && !eoi |=> $stable(statusOut)); // R11

endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/100ps
module prio_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqReq = '0;
  logic       maskWr = 1'b0;
  logic [7:0] maskData = '0;
  logic       baseWr = 1'b0;
  logic [7:0] baseData = '0;
  logic       intAck = 1'b0;
  logic       eoi = 1'b0;
  logic       intOut;
  logic [7:0] vectorOut, causeOut, statusOut;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq),
    .maskWr(maskWr), .maskData(maskData),
    .baseWr(baseWr), .baseData(baseData),
    .intAck(intAck), .eoi(eoi),
    .intOut(intOut), .vectorOut(vectorOut),
    .causeOut(causeOut), .statusOut(statusOut)
  );

  // each entry: {request pattern, mask, expected vector, expected intOut}
  localparam logic [31:0] VEC_TBL [6] = '{
    {8'h01, 8'h00, 8'h20, 8'h01},   // R3 lowest line
    {8'h80, 8'h00, 8'h27, 8'h01},   // R3 highest line
    {8'h29, 8'h00, 8'h25, 8'h01},   // R4 several lines
    {8'hFF, 8'h80, 8'h26, 8'h01},   // R4 R5 top masked
    {8'h0C, 8'h0C, 8'h00, 8'h00},   // R5 all masked
    {8'h81, 8'h80, 8'h20, 8'h01}    // R5 masked high, low wins
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step();
    step();
    rstN = 1'b1;
    step();
  endtask

  task automatic pulseIrq(input logic [7:0] v);
    irqReq = v;
    step();
    irqReq = '0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    step();
    intAck = 1'b0;
  endtask

  task automatic endInt();
    eoi = 1'b1;
    step();
    eoi = 1'b0;
  endtask

  task automatic writeMask(input logic [7:0] v);
    maskWr = 1'b1;
    maskData = v;
    step();
    maskWr = 1'b0;
  endtask

  task automatic writeBase(input logic [7:0] v);
    baseWr = 1'b1;
    baseData = v;
    step();
    baseWr = 1'b0;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    step();
    doReset();
    // R1 reset state
    chk(intOut, 0, "R1 intOut");
    chk(vectorOut, 8'h00, "R1 vector");
    chk(causeOut, 8'h00, "R1 cause");
    chk(statusOut, 8'h00, "R1 status");

    for (int n = 0; n < 6; n++) begin
      logic [7:0] req, msk, expV, expI;
      {req, msk, expV, expI} = VEC_TBL[n];
      doReset();
      writeMask(msk);
      pulseIrq(req);
      chk(causeOut, req & ~msk, "R2 table cause");
      chk(intOut, 0, "R3 table latency");
      step();
      chk(intOut, expI[0], "R3 R4 R5 table intOut");
      if (expI[0]) chk(vectorOut, expV, "R3 R4 table vector");
    end

    // nesting walk
    doReset();
    pulseIrq(8'h04);
    chk(causeOut, 8'h04, "R2 pending sticky");
    chk(intOut, 0, "R3 not yet");
    step();
    chk(intOut, 1, "R3 raised");
    chk(vectorOut, 8'h22, "R3 vector line2");
    pulseIrq(8'h80);
    step();
    chk(intOut, 1, "R6 held");
    chk(vectorOut, 8'h22, "R6 vector held");
    chk(causeOut, 8'h84, "R2 both pending");
    ack();
    chk(intOut, 0, "R7 drop");
    chk(statusOut, 8'h04, "R7 status");
    chk(causeOut, 8'h80, "R7 pending cleared");
    step();
    chk(intOut, 1, "R8 higher nests");
    chk(vectorOut, 8'h27, "R8 vector line7");
    ack();
    chk(statusOut, 8'h84, "R7 status nested");
    pulseIrq(8'hA0);
    step();
    step();
    chk(intOut, 0, "R8 lower and equal blocked");
    chk(causeOut, 8'hA0, "R8 still pending");
    endInt();
    chk(statusOut, 8'h04, "R9 pop top");
    chk(intOut, 0, "R9 quiet cycle");
    step();
    chk(intOut, 1, "R9 released");
    chk(vectorOut, 8'h27, "R4 R9 highest released");
    ack();
    chk(statusOut, 8'h84, "R7 status again");
    endInt();
    chk(intOut, 0, "R9 quiet cycle 2");
    step();
    chk(intOut, 1, "R9 line5 released");
    chk(vectorOut, 8'h25, "R9 vector line5");
    ack();
    chk(statusOut, 8'h24, "R7 status line5");
    endInt();
    endInt();
    chk(statusOut, 8'h00, "R9 stack empty");

    // mask, base, idle ack
    writeMask(8'h02);
    writeBase(8'h40);
    pulseIrq(8'h02);
    step();
    chk(causeOut, 8'h00, "R5 masked no cause");
    chk(intOut, 0, "R5 masked no int");
    ack();
    chk(statusOut, 8'h00, "R11 idle ack status");
    chk(intOut, 0, "R11 idle ack int");
    writeMask(8'h00);
    chk(causeOut, 8'h02, "R5 R10 unmask shows cause");
    chk(intOut, 0, "R10 quiet cycle");
    step();
    chk(intOut, 1, "R5 unmasked raises");
    chk(vectorOut, 8'h41, "R10 new base");
    ack();
    chk(statusOut, 8'h02, "R7 status line1");
    writeBase(8'hFE);
    pulseIrq(8'h08);
    step();
    chk(intOut, 1, "R8 line3 above line1");
    chk(vectorOut, 8'h01, "R3 vector wraps");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule